// File: doc/BRIEF.md
# Serial ADC host controller

This block runs single conversions on one or more 12-bit, 8-channel serial converters that sit on a shared 3-wire link: an active-low select line per converter, a common serial clock, and one common data line used in both directions. A request on `start` picks a converter and a channel setup. The block lowers that converter's select line, shifts out an 8-bit setup word, and hands the data line to the converter partway through the 8th serial clock. It then shifts in the 12-bit conversion result, raises the select line again, and reports the result with a one-cycle `done` pulse.

The serial clock comes from the system clock through a programmable half-period divider. It has a 50% duty cycle and stays low whenever no select line is low. The bidirectional data pin appears as three signals: `sdio_out`, `sdio_oe` and `sdio_in`. The pad ring builds the tri-state buffer from them. The result is available as a 12-bit word and as two bytes, laid out the way a byte-wide host would store it.

Top module: `adc_link_ctrl`

## Requirements
- R1: While reset is held and after it is released, all `cs_n` lines are high, `sclk` is low, and `busy`, `done` and `sdio_oe` are low.
- R2: A `start` sampled while idle makes `cs_n[dev_sel]` go low on that same clock edge, and `busy` goes high. Every other `cs_n` line stays high, so at most one select line is low at any time.
- R3: The setup word is 8 bits, sent first to last as: 1 (start marker), `sgl_ended`, `odd_sign`, `chan[1]`, `chan[0]`, `unipolar`, 1 (result MSB first), 1 (stay powered). Each bit is on `sdio_out`, with `sdio_oe` high, when the rising `sclk` edge that latches it occurs. Bits change only on falling edges.
- R4: `sdio_oe` falls exactly one system clock after the 8th rising `sclk` edge, while `sclk` is still high, so it is low before the 8th falling edge. It is never high while the converter drives the line.
- R5: The 12 result bits are sampled on rising `sclk` edges 9 to 20. The first sampled bit becomes `result[11]` and the last becomes `result[0]`.
- R6: `result_hi` equals `result[11:4]`. `result_lo` equals `{result[3:0], 4'b0000}`.
- R7: `done` is high for exactly one cycle, 40*HALF_DIV system clocks after the edge that accepted `start`. On that same edge all `cs_n` go high, `sclk` is low and `busy` falls.
- R8: The first rising `sclk` edge comes HALF_DIV clocks after the select line falls. `sclk` is then high for HALF_DIV clocks in each period of 2*HALF_DIV clocks. It is low whenever all `cs_n` are high.
- R9: A `start` that arrives while `busy` is high is ignored. The active select line and the setup word in flight do not change.
- R10: A `start` given in the cycle after `done` is accepted at once, with no extra idle cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Conversion request, sampled while idle |
| dev_sel | input | DEV_W | Index of the converter to address |
| chan | input | 2 | Channel select bits |
| sgl_ended | input | 1 | 1 = single-ended input, 0 = differential |
| odd_sign | input | 1 | Odd channel / polarity select |
| unipolar | input | 1 | 1 = unipolar range, 0 = bipolar |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | RES_W | Last conversion result |
| result_hi | output | 8 | Result bits 11..4 |
| result_lo | output | 8 | Result bits 3..0 in the upper nibble, zeros below |
| sclk | output | 1 | Serial clock |
| cs_n | output | N_DEV | Active-low select, one per converter |
| sdio_out | output | 1 | Data line value driven by the host |
| sdio_oe | output | 1 | Host output enable for the data line |
| sdio_in | input | 1 | Data line value seen by the host |

## Verification
Every event is timed from the edge that accepts `start`. The select line falls on that edge. Rising serial edge k comes (2k-1)*HALF_DIV clocks later, the output enable drops at 15*HALF_DIV+1, and `done` arrives at 40*HALF_DIV. The bench notes a free-running cycle index for each request it queues. Its converter model and its result monitor sample on the falling system clock edge and compare each event's cycle index with these offsets. The model also checks every setup bit at the rising serial edge that latches it.

// File: rtl/adc_link_pkg.sv
package adc_link_pkg;

  // Transaction phases: idle, sending setup word, receiving result.
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_CFG  = 2'd1,
    ST_RES  = 2'd2
  } xfer_st_e;

  // Setup word; the first member is the MSB and leaves the block first.
  typedef struct packed {
    logic       mark;
    logic       sgl;
    logic       odd;
    logic [1:0] chan;
    logic       uni;
    logic       msb_first;
    logic       stay_on;
  } cfg_word_t;

  localparam int CFG_BITS = $bits(cfg_word_t);

endpackage

// File: rtl/adc_rst_sync.sv
module adc_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= {sync_q[0], 1'b1};
    end
  end

  assign rst_n_sync = sync_q[1];

endmodule

// File: rtl/adc_sclk_gen.sv
// Half-period divider; HALF_DIV must be at least 2.
module adc_sclk_gen #(
  parameter int HALF_DIV = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic sclk,
  output logic rise_now,
  output logic fall_now
);

  localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          sclk_q, sclk_d;
  logic          tick;
  logic          cnt_en;

  always_comb begin
    tick   = run && (cnt_q == LAST);
    cnt_en = 1'b1;
    cnt_d  = cnt_q;
    sclk_d = sclk_q;
    if (!run) begin
      cnt_d  = '0;
      sclk_d = 1'b0;
    end else if (tick) begin
      cnt_d  = '0;
      sclk_d = ~sclk_q;
    end else begin
      cnt_d  = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      sclk_q <= 1'b0;
    end else if (cnt_en) begin
      cnt_q  <= cnt_d;
      sclk_q <= sclk_d;
    end
  end

  assign sclk     = sclk_q;
  assign rise_now = tick & ~sclk_q;
  assign fall_now = tick & sclk_q;

  AST_SCLK_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !tick) |=> $stable(sclk_q)); // R8

endmodule

// File: rtl/adc_sel_dec.sv
module adc_sel_dec #(
  parameter int N_DEV = 4,
  parameter int DEV_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             act_nx,
  input  logic [DEV_W-1:0] idx_nx,
  output logic [N_DEV-1:0] sel_n
);

  logic [N_DEV-1:0] sel_n_q, sel_n_d;
  logic             sel_en;

  assign sel_en = 1'b1;

  for (genvar g = 0; g < N_DEV; g++) begin : g_line
    assign sel_n_d[g] = ~(act_nx && (idx_nx == DEV_W'(g)));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_n_q <= '1;
    end else if (sel_en) begin
      sel_n_q <= sel_n_d;
    end
  end

  assign sel_n = sel_n_q;

  AST_SINGLE_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(~sel_n_q) <= 1); // R2

endmodule

// File: rtl/adc_xfer_fsm.sv
module adc_xfer_fsm
  import adc_link_pkg::*;
#(
  parameter int CFG_W = 8,
  parameter int RES_W = 12,
  parameter int DEV_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CFG_W-1:0] cfg_in,
  input  logic [DEV_W-1:0] dev_in,
  input  logic             rise_now,
  input  logic             fall_now,
  input  logic             sdio_in,
  output logic             busy,
  output logic             busy_nx,
  output logic [DEV_W-1:0] dev_nx,
  output logic             done,
  output logic [RES_W-1:0] result,
  output logic             sdio_out,
  output logic             sdio_oe
);

  localparam int N_EDGE = CFG_W + RES_W;
  localparam int RCW    = $clog2(N_EDGE + 1);
  localparam logic [RCW-1:0] CFG_END = RCW'(CFG_W);
  localparam logic [RCW-1:0] RES_END = RCW'(N_EDGE);

  xfer_st_e         st_q, st_d;
  logic [RCW-1:0]   rcnt_q, rcnt_d;
  logic             oe_q, oe_d;
  logic             done_q, done_d;
  logic [CFG_W-1:0] cw_q;
  logic [RES_W-1:0] rx_q, res_q;
  logic [DEV_W-1:0] dev_q;
  logic             cw_ld, cw_sh, rx_sh, res_ld;

  // Next-state and enables.
  always_comb begin
    st_d   = st_q;
    rcnt_d = rcnt_q;
    oe_d   = oe_q;
    done_d = 1'b0;
    cw_ld  = 1'b0;
    cw_sh  = 1'b0;
    rx_sh  = 1'b0;
    res_ld = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (start) begin
          st_d   = ST_CFG;
          rcnt_d = '0;
          oe_d   = 1'b1;
          cw_ld  = 1'b1;
        end
      end
      ST_CFG: begin
        if (rise_now) begin
          rcnt_d = rcnt_q + 1'b1;
        end
        // Let go of the line one clock after the last setup bit is latched.
        if (oe_q && (rcnt_q == CFG_END)) begin
          oe_d = 1'b0;
        end
        if (fall_now) begin
          if (rcnt_q == CFG_END) begin
            st_d = ST_RES;
          end else begin
            cw_sh = 1'b1;
          end
        end
      end
      ST_RES: begin
        if (rise_now) begin
          rcnt_d = rcnt_q + 1'b1;
          rx_sh  = 1'b1;
        end
        if (fall_now && (rcnt_q == RES_END)) begin
          st_d   = ST_IDLE;
          done_d = 1'b1;
          res_ld = 1'b1;
        end
      end
      default: begin
        st_d = ST_IDLE;
      end
    endcase
  end

  // Control registers.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      rcnt_q <= '0;
      oe_q   <= 1'b0;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      rcnt_q <= rcnt_d;
      oe_q   <= oe_d;
      done_q <= done_d;
    end
  end

  // Datapath registers with explicit enables.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cw_q  <= '0;
      dev_q <= '0;
    end else if (cw_ld) begin
      cw_q  <= cfg_in;
      dev_q <= dev_in;
    end else if (cw_sh) begin
      cw_q  <= {cw_q[CFG_W-2:0], 1'b0};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_q <= '0;
    end else if (rx_sh) begin
      rx_q <= {rx_q[RES_W-2:0], sdio_in};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_q <= '0;
    end else if (res_ld) begin
      res_q <= rx_q;
    end
  end

  assign busy     = (st_q != ST_IDLE);
  assign busy_nx  = (st_d != ST_IDLE);
  assign dev_nx   = cw_ld ? dev_in : dev_q;
  assign done     = done_q;
  assign result   = res_q;
  assign sdio_oe  = oe_q;
  assign sdio_out = oe_q & cw_q[CFG_W-1];

  AST_CFG_DRIVEN_AT_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    (rise_now && (st_q == ST_CFG)) |-> oe_q); // R3

  AST_RELEASE_BEFORE_FALL8: assert property (@(posedge clk) disable iff (!rst_n)
    (fall_now && (st_q == ST_CFG) && (rcnt_q == CFG_END)) |-> !oe_q); // R4

  AST_NO_DRIVE_IN_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_RES) |-> !oe_q); // R4

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q); // R7

endmodule

// File: rtl/adc_link_ctrl.sv
module adc_link_ctrl
  import adc_link_pkg::*;
#(
  parameter int   HALF_DIV  = 2,
  parameter int   N_DEV     = 4,
  parameter int   RES_W     = 12,
  parameter logic ORDER_MSB = 1'b1,
  parameter logic STAY_ON   = 1'b1,
  localparam int  DEV_W     = (N_DEV > 1) ? $clog2(N_DEV) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [DEV_W-1:0] dev_sel,
  input  logic [1:0]       chan,
  input  logic             sgl_ended,
  input  logic             odd_sign,
  input  logic             unipolar,
  output logic             busy,
  output logic             done,
  output logic [RES_W-1:0] result,
  output logic [7:0]       result_hi,
  output logic [7:0]       result_lo,
  output logic             sclk,
  output logic [N_DEV-1:0] cs_n,
  output logic             sdio_out,
  output logic             sdio_oe,
  input  logic             sdio_in
);

  logic             rst_q;
  cfg_word_t        cfg_w;
  logic             rise_now, fall_now;
  logic             busy_nx;
  logic [DEV_W-1:0] dev_nx;

  adc_rst_sync i_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_q)
  );

  always_comb begin
    cfg_w.mark      = 1'b1;
    cfg_w.sgl       = sgl_ended;
    cfg_w.odd       = odd_sign;
    cfg_w.chan      = chan;
    cfg_w.uni       = unipolar;
    cfg_w.msb_first = ORDER_MSB;
    cfg_w.stay_on   = STAY_ON;
  end

  adc_sclk_gen #(.HALF_DIV(HALF_DIV)) i_sclk (
    .clk      (clk),
    .rst_n    (rst_q),
    .run      (busy),
    .sclk     (sclk),
    .rise_now (rise_now),
    .fall_now (fall_now)
  );

  adc_xfer_fsm #(.CFG_W(CFG_BITS), .RES_W(RES_W), .DEV_W(DEV_W)) i_fsm (
    .clk      (clk),
    .rst_n    (rst_q),
    .start    (start),
    .cfg_in   (cfg_w),
    .dev_in   (dev_sel),
    .rise_now (rise_now),
    .fall_now (fall_now),
    .sdio_in  (sdio_in),
    .busy     (busy),
    .busy_nx  (busy_nx),
    .dev_nx   (dev_nx),
    .done     (done),
    .result   (result),
    .sdio_out (sdio_out),
    .sdio_oe  (sdio_oe)
  );

  adc_sel_dec #(.N_DEV(N_DEV), .DEV_W(DEV_W)) i_sel (
    .clk    (clk),
    .rst_n  (rst_q),
    .act_nx (busy_nx),
    .idx_nx (dev_nx),
    .sel_n  (cs_n)
  );

  assign result_hi = result[RES_W-1 -: 8];
  assign result_lo = {result[RES_W-9:0], {(16-RES_W){1'b0}}};

  AST_SCLK_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_q)
    (&cs_n) |-> !sclk); // R8

  AST_SEL_HELD: assert property (@(posedge clk) disable iff (!rst_q)
    busy |=> (done || $stable(cs_n))); // R9

  AST_SEL_MATCHES_BUSY: assert property (@(posedge clk) disable iff (!rst_q)
    busy |-> !(&cs_n)); // R2

endmodule

// File: tb/test_adc_link_ctrl.sv
module test_adc_link_ctrl;

  localparam int HALF = 3;
  localparam int NDEV = 4;
  localparam int LAT  = 40 * HALF;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [1:0]  dev_sel = 2'd0;
  logic [1:0]  chan = 2'd0;
  logic        sgl_ended = 1'b0;
  logic        odd_sign = 1'b0;
  logic        unipolar = 1'b0;
  logic        busy, done, sclk, sdio_out, sdio_oe, sdio_in;
  logic [11:0] result;
  logic [7:0]  result_hi, result_lo;
  logic [3:0]  cs_n;

  always #2 clk = ~clk;

  adc_link_ctrl #(.HALF_DIV(HALF), .N_DEV(NDEV)) i_adc_link_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .dev_sel(dev_sel), .chan(chan),
    .sgl_ended(sgl_ended), .odd_sign(odd_sign), .unipolar(unipolar),
    .busy(busy), .done(done), .result(result), .result_hi(result_hi),
    .result_lo(result_lo), .sclk(sclk), .cs_n(cs_n), .sdio_out(sdio_out),
    .sdio_oe(sdio_oe), .sdio_in(sdio_in)
  );

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  bit finished = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  typedef struct {
    int          dev;
    logic [7:0]  cfg;
    logic [11:0] val;
    int          t0;
  } item_t;

  item_t exp_q[$];

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  // Converter model: checks setup bits, drives result, watches timing.
  logic       drv = 1'b0;
  logic       drv_bit = 1'b0;
  logic       sclk_prev = 1'b0;
  logic       oe_prev = 1'b0;
  logic [3:0] cs_prev = 4'hF;
  int         redge = 0;
  int         t_rise = 0;
  int         t_sel = 0;

  assign sdio_in = drv ? drv_bit : 1'b0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (drv && sdio_oe) chk(1'b0, "R4", "both sides drive data line", 1, 0);
      if (oe_prev && !sdio_oe)
        chk(sclk && redge == 8 && (cyc - t_rise) == 1, "R4", "release cycles after 8th rise",
            cyc - t_rise, 1);
      if (cs_prev == 4'hF && cs_n != 4'hF) begin
        redge = 0;
        t_sel = cyc;
        if (exp_q.size() == 0) chk(1'b0, "R9", "select without accepted request", int'(cs_n), 15);
        else begin
          chk(cs_n == ~(4'(1) << exp_q[0].dev), "R2", "select lines", int'(cs_n),
              int'(~(4'(1) << exp_q[0].dev)));
          chk(cyc == exp_q[0].t0, "R10", "select fall cycle", cyc, exp_q[0].t0);
        end
      end
      if (sclk && !sclk_prev) begin
        redge++;
        if (redge == 1) chk((cyc - t_sel) == HALF, "R8", "first rise delay", cyc - t_sel, HALF);
        else chk((cyc - t_rise) == 2 * HALF, "R8", "sclk period", cyc - t_rise, 2 * HALF);
        t_rise = cyc;
        if (redge <= 8 && exp_q.size() > 0)
          chk(sdio_oe && sdio_out == exp_q[0].cfg[8 - redge], "R3", "setup bit", int'(sdio_out),
              int'(exp_q[0].cfg[8 - redge]));
      end
      if (!sclk && sclk_prev) begin
        chk((cyc - t_rise) == HALF, "R8", "sclk high time", cyc - t_rise, HALF);
        if (redge >= 8 && redge < 20 && exp_q.size() > 0) begin
          drv = 1'b1;
          drv_bit = exp_q[0].val[19 - redge];
        end
      end
      if (cs_n == 4'hF && cs_prev != 4'hF) begin
        drv = 1'b0;
        chk(!sclk, "R8", "sclk low once deselected", int'(sclk), 0);
      end
      sclk_prev = sclk;
      cs_prev = cs_n;
      oe_prev = sdio_oe;
    end
  end

  // Monitor: pops expected items as results appear.
  always @(negedge clk) begin
    if (rst_n && done) begin
      if (exp_q.size() == 0) chk(1'b0, "R5", "done without request", 1, 0);
      else begin
        item_t e;
        e = exp_q.pop_front();
        chk(result == e.val, "R5", "result", int'(result), int'(e.val));
        chk(result_hi == e.val[11:4], "R6", "high byte", int'(result_hi), int'(e.val[11:4]));
        chk(result_lo == {e.val[3:0], 4'h0}, "R6", "low byte", int'(result_lo),
            int'({e.val[3:0], 4'h0}));
        chk((cyc - e.t0) == LAT, "R7", "done latency", cyc - e.t0, LAT);
        chk(cs_n == 4'hF && !sclk && !busy, "R7", "idle at done", int'({busy, sclk, cs_n}), 15);
      end
    end
  end

  task automatic run_conv(input int dev, input logic [1:0] ch, input bit sgl, input bit odd,
                          input bit uni, input logic [11:0] val);
    item_t it;
    while (busy) @(negedge clk);
    it.dev = dev;
    it.cfg = {1'b1, sgl, odd, ch, uni, 1'b1, 1'b1};
    it.val = val;
    it.t0  = cyc + 1;
    exp_q.push_back(it);
    start = 1'b1;
    dev_sel = 2'(dev);
    chan = ch;
    sgl_ended = sgl;
    odd_sign = odd;
    unipolar = uni;
    @(negedge clk);
    start = 1'b0;
    chk(busy, "R2", "busy after start", int'(busy), 1);
  endtask

  task automatic poke_while_busy(input int dev, input int orig);
    while (!busy) @(negedge clk);
    repeat (10) @(negedge clk);
    start = 1'b1;
    dev_sel = 2'(dev);
    chan = ~chan;
    sgl_ended = ~sgl_ended;
    @(negedge clk);
    start = 1'b0;
    repeat (2) @(negedge clk);
    chk(busy && cs_n == ~(4'(1) << orig), "R9", "select after ignored start", int'(cs_n),
        int'(~(4'(1) << orig)));
  endtask

  initial begin
    repeat (4) @(negedge clk);
    chk(cs_n == 4'hF && !sclk && !busy && !done && !sdio_oe, "R1", "state in reset",
        int'({sdio_oe, done, busy, sclk, cs_n}), 15);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(cs_n == 4'hF && !sclk && !busy && !done && !sdio_oe, "R1", "state after reset",
        int'({sdio_oe, done, busy, sclk, cs_n}), 15);

    run_conv(0, 2'b00, 1'b0, 1'b0, 1'b1, 12'hA5C);
    run_conv(3, 2'b11, 1'b1, 1'b1, 1'b0, 12'h001);
    poke_while_busy(2, 3);
    run_conv(1, 2'b10, 1'b1, 1'b0, 1'b1, 12'hFFF);
    run_conv(2, 2'b01, 1'b0, 1'b1, 1'b0, 12'h800);
    run_conv(1, 2'b01, 1'b1, 1'b0, 1'b0, 12'h7FE);
    run_conv(0, 2'b10, 1'b0, 1'b1, 1'b1, 12'h36B);

    while (busy || exp_q.size() != 0) @(negedge clk);
    repeat (5) @(negedge clk);
    chk(cs_n == 4'hF && !sclk && !sdio_oe, "R8", "idle lines at end", int'({sdio_oe, sclk, cs_n}),
        15);
    report();
  end

  initial begin
    repeat (20000) @(posedge clk);
    @(negedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

endmodule